// File: doc/BRIEF.md
# Vectorized Reference-Block Read Address Generator

This block turns the integer pixel position of a motion-compensation reference block into DRAM read commands for a frame stored as vectorized 4x4 sub-blocks. Each sub-block occupies two consecutive memory locations. Sub-block order across the image is kept, so neighbours in the picture stay neighbours in memory. With bank interleaving enabled, each new row of sub-blocks goes to the next of eight banks. This means the rows touched by one reference window fall in different banks.

The caller supplies the pixel coordinate of the block after adding the integer part of the motion vector. It also supplies the fractional motion-vector bits and a base row for the frame, then pulses `start`. The fractional bits set the size of the window the interpolation filter needs. The block issues one read command per sub-block row that the window covers, from the top row down, on consecutive cycles. Each command carries bank, row, bus column and burst length. After the last command it raises `done` for one cycle. Alongside the commands it holds the pixel offsets that a downstream repacker needs to locate the window start inside the returned data.

Top module: `vecaddr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `cmdValid` and `done` are low and `busy` is low until a start is accepted.
- R2: The fractional codes per axis are 0 = integer, 2 = half, 1 and 3 = quarter. Both zero gives a 4x4 window. `fracX`=2 with `fracY`=0 gives 4 rows by 9 columns. `fracX`=0 with `fracY`=2 gives 9 rows by 4 columns. Every other combination gives 9x9.
- R3: On an axis whose window extent is 9, the window runs from coordinate−2 to coordinate+6, with the start clamped at 0. On an axis whose extent is 4, it runs from the coordinate to coordinate+3.
- R4: For a command on sub-block row s (pixel row / 4), the bank is s mod 8 and the row is `baseRow` + s/8, modulo 2^13. When interleaving is disabled by parameter, the bank is 0 and the row is `baseRow` + s.
- R5: `cmdCol` equals the location column (2 × the sub-block column of the window start) with its two low bits dropped. That is, it is the window-start sub-block column divided by 2.
- R6: `cmdBurst` is 1 when the window's first and last sub-block columns lie in the same pair of sub-blocks (same value of column/2), and 2 otherwise. It is the same for every command of one window.
- R7: Commands appear on consecutive cycles, starting in the cycle after `start` is sampled, one per covered sub-block row in ascending row order. A window is served by 1 to 3 commands.
- R8: `done` is high for exactly one cycle, in the cycle right after the last command, and never together with `cmdValid`.
- R9: `selX` equals bits [2:0] of the window start column and `selY` equals bits [1:0] of the window start row. Both are valid from the first command and held until the next accepted start.
- R10: A `start` pulse while `busy` is high has no effect on the commands, the offsets or the return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled when idle |
| pixX | input | 11 | Block column in pixels (macroblock, sub-block and pixel fields) |
| pixY | input | 11 | Block row in pixels |
| fracX | input | 2 | Horizontal fractional motion-vector bits |
| fracY | input | 2 | Vertical fractional motion-vector bits |
| baseRow | input | 13 | Row offset of the frame in each bank |
| cmdValid | output | 1 | A read command is presented this cycle |
| cmdBank | output | 3 | Bank of the command |
| cmdRow | output | 13 | DRAM row of the command |
| cmdCol | output | 8 | Bus column (location column without two low bits) |
| cmdBurst | output | 2 | Burst length, 1 or 2 |
| selX | output | 3 | Column offset of window start inside the fetched data |
| selY | output | 2 | Row offset of window start inside the first sub-block row |
| done | output | 1 | One-cycle pulse after the last command |
| busy | output | 1 | A request is being served |

## Verification
A wrong row counter or row-count latch shows at the ports within one cycle of the error. It appears as a bank that does not step by one, as a command too many or too few, or as `done` arriving early or late. A corrupt window latch shows on the first command: the column, burst or select offsets differ from the values computed from the coordinate. The bench therefore compares every command and the `done` cycle against a model of the window arithmetic. It places coordinates on sub-block edges, on bank wrap, at the left and top image edge, and at row-address wrap.

// File: rtl/vecaddr_pkg.sv
package vecaddr_pkg;

  typedef struct packed {
    logic load;
    logic advance;
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DONE  = 2'd2
  } genState_t;

endpackage

// File: rtl/vecaddr_dp.sv
module vecaddr_dp
  import vecaddr_pkg::*;
#(
  parameter int MB_W       = 7,
  parameter int SUB_W      = 2,
  parameter int PIX_W      = 2,
  parameter int BANK_W     = 3,
  parameter int ROW_W      = 13,
  parameter int COL_W      = 10,
  parameter bit INTERLEAVE = 1'b1,
  localparam int CRD_W     = MB_W + SUB_W + PIX_W,
  localparam int SB_W      = MB_W + SUB_W,
  localparam int BUSCOL_W  = COL_W - 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [CRD_W-1:0]    pixX,
  input  logic [CRD_W-1:0]    pixY,
  input  logic [1:0]          fracX,
  input  logic [1:0]          fracY,
  input  logic [ROW_W-1:0]    baseRow,
  output logic [BANK_W-1:0]   cmdBank,
  output logic [ROW_W-1:0]    cmdRow,
  output logic [BUSCOL_W-1:0] cmdCol,
  output logic [1:0]          cmdBurst,
  output logic [PIX_W:0]      selX,
  output logic [PIX_W-1:0]    selY,
  output logic                lastRow
);

  // window shape from the fractional bits
  logic isInt, isHalfH, isHalfV, extX, extY;
  always_comb begin
    isInt   = (fracX == 2'd0) && (fracY == 2'd0);
    isHalfH = (fracX == 2'd2) && (fracY == 2'd0);
    isHalfV = (fracX == 2'd0) && (fracY == 2'd2);
    extX    = !isInt && !isHalfV;
    extY    = !isInt && !isHalfH;
  end

  // window corners in pixels
  logic [CRD_W-1:0] xStart, xEnd, yStart, yEnd;
  always_comb begin
    if (extX) begin
      xStart = (pixX < CRD_W'(2)) ? '0 : pixX - CRD_W'(2);
      xEnd   = pixX + CRD_W'(6);
    end else begin
      xStart = pixX;
      xEnd   = pixX + CRD_W'(3);
    end
    if (extY) begin
      yStart = (pixY < CRD_W'(2)) ? '0 : pixY - CRD_W'(2);
      yEnd   = pixY + CRD_W'(6);
    end else begin
      yStart = pixY;
      yEnd   = pixY + CRD_W'(3);
    end
  end

  // sub-block indices and fetch geometry
  logic [SB_W-1:0]     sbColFirst, sbColLast, sbRowFirst, sbRowLast;
  logic [BUSCOL_W-1:0] pairFirst, pairLast;
  logic [1:0]          rowCntNext;
  always_comb begin
    sbColFirst = SB_W'(xStart >> PIX_W);
    sbColLast  = SB_W'(xEnd >> PIX_W);
    sbRowFirst = SB_W'(yStart >> PIX_W);
    sbRowLast  = SB_W'(yEnd >> PIX_W);
    pairFirst  = BUSCOL_W'(sbColFirst >> 1);
    pairLast   = BUSCOL_W'(sbColLast >> 1);
    rowCntNext = 2'(sbRowLast - sbRowFirst) + 2'd1;
  end

  // request latch
  logic [SB_W-1:0]     rowFirstQ;
  logic [1:0]          rowCntQ, rowIdxQ, burstQ;
  logic [BUSCOL_W-1:0] colQ;
  logic [ROW_W-1:0]    baseQ;
  logic [PIX_W:0]      selXQ;
  logic [PIX_W-1:0]    selYQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowFirstQ <= '0;
      rowCntQ   <= 2'd1;
      rowIdxQ   <= '0;
      burstQ    <= 2'd1;
      colQ      <= '0;
      baseQ     <= '0;
      selXQ     <= '0;
      selYQ     <= '0;
    end else if (strobe.load) begin
      rowFirstQ <= sbRowFirst;
      rowCntQ   <= rowCntNext;
      rowIdxQ   <= '0;
      burstQ    <= (pairFirst == pairLast) ? 2'd1 : 2'd2;
      colQ      <= pairFirst;
      baseQ     <= baseRow;
      selXQ     <= xStart[PIX_W:0];
      selYQ     <= yStart[PIX_W-1:0];
    end else if (strobe.advance) begin
      rowIdxQ   <= rowIdxQ + 2'd1;
    end
  end

  logic [SB_W-1:0] curSbRow;
  assign curSbRow = rowFirstQ + SB_W'(rowIdxQ);

  generate
    if (INTERLEAVE) begin : g_interleave
      assign cmdBank = curSbRow[BANK_W-1:0];
      assign cmdRow  = baseQ + ROW_W'(curSbRow >> BANK_W);
    end else begin : g_linear
      assign cmdBank = '0;
      assign cmdRow  = baseQ + ROW_W'(curSbRow);
    end
  endgenerate

  assign cmdCol   = colQ;
  assign cmdBurst = burstQ;
  assign selX     = selXQ;
  assign selY     = selYQ;
  assign lastRow  = (rowIdxQ == rowCntQ - 2'd1);

endmodule

// File: rtl/vecaddr_ctrl.sv
module vecaddr_ctrl
  import vecaddr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        lastRow,
  output ctrlStrobe_t strobe,
  output logic        cmdValid,
  output logic        done,
  output logic        busy
);

  genState_t state, stateNext;

  always_comb begin
    stateNext      = state;
    strobe.load    = 1'b0;
    strobe.advance = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNext   = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (lastRow) stateNext = ST_DONE;
        else         strobe.advance = 1'b1;
      end
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign cmdValid = (state == ST_ISSUE);
  assign done     = (state == ST_DONE);
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/vecaddr_gen.sv
module vecaddr_gen
  import vecaddr_pkg::*;
#(
  parameter int MB_W       = 7,
  parameter int SUB_W      = 2,
  parameter int PIX_W      = 2,
  parameter int BANK_W     = 3,
  parameter int ROW_W      = 13,
  parameter int COL_W      = 10,
  parameter bit INTERLEAVE = 1'b1,
  localparam int CRD_W     = MB_W + SUB_W + PIX_W,
  localparam int BUSCOL_W  = COL_W - 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [CRD_W-1:0]    pixX,
  input  logic [CRD_W-1:0]    pixY,
  input  logic [1:0]          fracX,
  input  logic [1:0]          fracY,
  input  logic [ROW_W-1:0]    baseRow,
  output logic                cmdValid,
  output logic [BANK_W-1:0]   cmdBank,
  output logic [ROW_W-1:0]    cmdRow,
  output logic [BUSCOL_W-1:0] cmdCol,
  output logic [1:0]          cmdBurst,
  output logic [PIX_W:0]      selX,
  output logic [PIX_W-1:0]    selY,
  output logic                done,
  output logic                busy
);

  ctrlStrobe_t strobe;
  logic        lastRow;

  vecaddr_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .lastRow  (lastRow),
    .strobe   (strobe),
    .cmdValid (cmdValid),
    .done     (done),
    .busy     (busy)
  );

  vecaddr_dp #(
    .MB_W       (MB_W),
    .SUB_W      (SUB_W),
    .PIX_W      (PIX_W),
    .BANK_W     (BANK_W),
    .ROW_W      (ROW_W),
    .COL_W      (COL_W),
    .INTERLEAVE (INTERLEAVE)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pixX     (pixX),
    .pixY     (pixY),
    .fracX    (fracX),
    .fracY    (fracY),
    .baseRow  (baseRow),
    .cmdBank  (cmdBank),
    .cmdRow   (cmdRow),
    .cmdCol   (cmdCol),
    .cmdBurst (cmdBurst),
    .selX     (selX),
    .selY     (selY),
    .lastRow  (lastRow)
  );

endmodule

// File: rtl/vecaddr_chk.sv
module vecaddr_chk #(
  parameter int BANK_W     = 3,
  parameter int BUSCOL_W   = 8,
  parameter int PIX_W      = 2,
  parameter bit INTERLEAVE = 1'b1
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic [BANK_W-1:0]   cmdBank,
  input logic [BUSCOL_W-1:0] cmdCol,
  input logic [1:0]          cmdBurst,
  input logic [PIX_W:0]      selX,
  input logic [PIX_W-1:0]    selY,
  input logic                done,
  input logic                busy
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!cmdValid && !done));

  // R6
  burst_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdBurst == 2'd1 || cmdBurst == 2'd2));

  // R6
  col_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && $past(cmdValid)) |-> ($stable(cmdCol) && $stable(cmdBurst)));

  // R7
  max_rows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && $past(cmdValid) && $past(cmdValid, 2)) |=> !cmdValid);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(cmdValid) && !cmdValid));

  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && $past(cmdValid)) |-> ($stable(selX) && $stable(selY)));

  generate
    if (INTERLEAVE) begin : g_bank_step
      // R4
      bank_step_chk: assert property (@(posedge clk) disable iff (!rstN)
        (cmdValid && $past(cmdValid)) |-> (cmdBank == $past(cmdBank) + BANK_W'(1)));
    end else begin : g_bank_fixed
      // R4
      bank_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
        cmdValid |-> (cmdBank == '0));
    end
  endgenerate

endmodule

bind vecaddr_gen vecaddr_chk #(
  .BANK_W     (BANK_W),
  .BUSCOL_W   (BUSCOL_W),
  .PIX_W      (PIX_W),
  .INTERLEAVE (INTERLEAVE)
) i_vecaddr_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdBank  (cmdBank),
  .cmdCol   (cmdCol),
  .cmdBurst (cmdBurst),
  .selX     (selX),
  .selY     (selY),
  .done     (done),
  .busy     (busy)
);

// File: tb/test_vecaddr_gen.sv
module test_vecaddr_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [10:0] pixX = '0, pixY = '0;
  logic [1:0]  fracX = '0, fracY = '0;
  logic [12:0] baseRow = '0;
  logic        cmdValid, done, busy;
  logic [2:0]  cmdBank;
  logic [12:0] cmdRow;
  logic [7:0]  cmdCol;
  logic [1:0]  cmdBurst;
  logic [2:0]  selX;
  logic [1:0]  selY;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vecaddr_gen i_vecaddr_gen (
    .clk(clk), .rstN(rstN), .start(start), .pixX(pixX), .pixY(pixY),
    .fracX(fracX), .fracY(fracY), .baseRow(baseRow),
    .cmdValid(cmdValid), .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol),
    .cmdBurst(cmdBurst), .selX(selX), .selY(selY), .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // window model built from R2, R3, R5, R6, R9
  task automatic model(input int x, input int y, input int fx, input int fy,
                       output int n, output int rowFirst, output int col,
                       output int burst, output int sx, output int sy);
    bit isInt, hh, vh, exX, exY;
    int xs, xe, ys, ye;
    isInt = (fx == 0) && (fy == 0);
    hh    = (fx == 2) && (fy == 0);
    vh    = (fx == 0) && (fy == 2);
    exX   = !isInt && !vh;
    exY   = !isInt && !hh;
    xs = exX ? ((x < 2) ? 0 : x - 2) : x;
    xe = exX ? x + 6 : x + 3;
    ys = exY ? ((y < 2) ? 0 : y - 2) : y;
    ye = exY ? y + 6 : y + 3;
    col      = (xs / 4) / 2;
    burst    = (((xs / 4) / 2) == ((xe / 4) / 2)) ? 1 : 2;
    rowFirst = ys / 4;
    n        = ye / 4 - ys / 4 + 1;
    sx       = xs % 8;
    sy       = ys % 4;
  endtask

  task automatic runCase(input string name, input int x, input int y,
                         input int fx, input int fy, input int base,
                         input bit poke);
    int n, rf, col, burst, sx, sy;
    model(x, y, fx, fy, n, rf, col, burst, sx, sy);
    @(negedge clk);
    pixX = 11'(x); pixY = 11'(y); fracX = 2'(fx); fracY = 2'(fy);
    baseRow = 13'(base); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      int sr;
      sr = rf + i;
      chk(cmdValid == 1'b1, "R7", {name, " valid"}, int'(cmdValid), 1);
      chk(cmdBank == 3'(sr % 8), "R4", {name, " bank"}, int'(cmdBank), sr % 8);
      chk(cmdRow == 13'((base + sr / 8) % 8192), "R4", {name, " row"},
          int'(cmdRow), (base + sr / 8) % 8192);
      chk(cmdCol == 8'(col), "R5", {name, " col"}, int'(cmdCol), col);
      chk(cmdBurst == 2'(burst), "R6", {name, " burst"}, int'(cmdBurst), burst);
      chk(selX == 3'(sx), "R9", {name, " selX"}, int'(selX), sx);
      chk(selY == 2'(sy), "R9", {name, " selY"}, int'(selY), sy);
      chk(done == 1'b0, "R8", {name, " early done"}, int'(done), 0);
      if (poke && i == 1) begin
        // R10: foreign request while busy
        pixX = 11'(x + 100); pixY = 11'(y + 40); fracX = 2'd0; fracY = 2'd0;
        baseRow = 13'(base + 7); start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
    end
    chk(done == 1'b1 && cmdValid == 1'b0, "R8", {name, " done pulse"},
        int'({done, cmdValid}), 2);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R8", {name, " done width"},
        int'({done, busy}), 0);
    if (poke) begin
      @(negedge clk);
      chk(cmdValid == 1'b0 && busy == 1'b0, "R10", {name, " no extra request"},
          int'({cmdValid, busy}), 0);
      chk(selX == 3'(sx) && selY == 2'(sy), "R10", {name, " offsets kept"},
          int'({selX, selY}), (sx << 2) | sy);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(cmdValid == 1'b0 && done == 1'b0 && busy == 1'b0, "R1", "in reset",
        int'({cmdValid, done, busy}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(cmdValid == 1'b0 && done == 1'b0 && busy == 1'b0, "R1", "after reset",
        int'({cmdValid, done, busy}), 0);

    runCase("R2 int aligned",      16,   8, 0, 0,    0, 1'b0);
    runCase("R7 int two rows",     16,  10, 0, 0,    0, 1'b0);
    runCase("R2 half horiz",        8,   4, 2, 0,    0, 1'b0);
    runCase("R2 half vert",        20,  20, 0, 2,    0, 1'b0);
    runCase("R4 quarter bank wrap", 33,  30, 1, 3,    5, 1'b0);
    runCase("R3 edge clamp",        1,   0, 2, 2,    0, 1'b0);
    runCase("R4 row wrap",       1000,1500, 1, 1, 8190, 1'b0);
    runCase("R3 half centre",      13,  17, 2, 2,   12, 1'b0);
    runCase("R10 start while busy", 44,  26, 3, 0,    3, 1'b1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule